// File: doc/BRIEF.md
# HDLC Channel Event and Interrupt Mask Unit

This block gathers the status activity of one HDLC serial channel and turns it into sticky event bits in a 16-bit event register. Receive and transmit logic feed it single-cycle pulses (clock glitches, transmit error, frame received, busy, buffer done) and three live levels (flags being received, line idle, carrier sense). A change of a level in either direction counts as an event. The block also follows a graceful-stop-transmit command until it completes, and reports that completion as an event.

A mask register with the same layout selects which events may raise the single interrupt request. Software reaches both registers through a plain one-cycle register port: `reg_sel` chooses the register, `reg_wr` writes it, and `reg_rdata` always shows the chosen register. The port has no handshake and every access completes in one cycle. Event bits are cleared by writing ones. Bits are numbered with bit 0 as the most significant, so field bit n sits at vector index 15-n.

Top module: `hdlc_evt_unit`

## Requirements
- R1: After reset the event register, the mask register and `irq` are all zero.
- R2: Field bits 0, 1, 2, 9 and 10 (vector mask 0xE060) always read as zero in both registers, and writes to them are ignored, so a mask write of 0xFFFF reads back 0x1F9F.
- R3: A one-cycle pulse sets its event bit at the next clock edge: rx glitch bit 3 (0x1000), tx glitch bit 4 (0x0800), tx error bit 11 (0x0010), frame received bit 12 (0x0008), busy bit 13 (0x0004), tx buffer done bit 14 (0x0002), rx buffer done bit 15 (0x0001).
- R4: A change in either direction of the carrier level sets bit 5 (0x0400), of the flag level sets bit 6 (0x0200), and of the idle level sets bit 7 (0x0100). A level that holds its value sets nothing, and a level already high when reset ends sets nothing.
- R5: A graceful-stop command seen while no frame is being sent sets bit 7's neighbour, bit 8 (0x0080), at that same clock edge.
- R6: A graceful-stop command seen while a frame is being sent sets bit 8 only at the first edge where `tx_frame_active` is low again.
- R7: With `reg_sel`=0, writing 1 to an event bit clears it, and writing 0 leaves it unchanged.
- R8: If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R9: With `reg_sel`=1 a write loads the mask, and `irq` is high exactly when some event bit is set and its mask bit is 1.
- R10: `irq` stays high until every unmasked event bit has been cleared, and masked events never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_flag | input | 1 | Live level: HDLC flags being received |
| lvl_idle | input | 1 | Live level: line idle |
| lvl_carrier | input | 1 | Live level: carrier sense from clock recovery |
| pls_rx_glitch | input | 1 | Pulse: receive clock glitch |
| pls_tx_glitch | input | 1 | Pulse: transmit clock glitch |
| pls_tx_err | input | 1 | Pulse: transmit error (CTS lost or underrun) |
| pls_rx_frame | input | 1 | Pulse: frame received |
| pls_busy | input | 1 | Pulse: busy condition |
| pls_tx_buf | input | 1 | Pulse: transmit buffer done |
| pls_rx_buf | input | 1 | Pulse: receive buffer done |
| tx_frame_active | input | 1 | High while the transmitter sends a frame |
| gstop_cmd | input | 1 | Pulse: graceful stop transmit command |
| reg_sel | input | 1 | 0 selects the event register, 1 the mask register |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Contents of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
A wrong internal state shows at the ports within one clock: every event sets its bit at the edge that samples it, so a bad bit mapping, a missed edge on a level, or a stale previous sample appears on `reg_rdata` in the next cycle. A graceful stop that is tracked wrongly shows either as bit 8 appearing while `tx_frame_active` is still high or as bit 8 missing in the cycle after the frame ends. A corrupted mask or event bit shows on `irq` at once, because the request is formed directly from the two registers.

// File: rtl/hdlc_evt_pkg.sv
package hdlc_evt_pkg;
  localparam int REG_W = 16;
  localparam int N_LVL = 3;
  localparam int N_PLS = 7;

  // field bit number (0 = MSB) to vector index
  function automatic int fidx(input int fbit);
    return REG_W - 1 - fbit;
  endfunction

  localparam int F_RXG = 3;
  localparam int F_TXG = 4;
  localparam int F_CAR = 5;
  localparam int F_FLG = 6;
  localparam int F_IDL = 7;
  localparam int F_GST = 8;
  localparam int F_TXE = 11;
  localparam int F_RXF = 12;
  localparam int F_BSY = 13;
  localparam int F_TXB = 14;
  localparam int F_RXB = 15;

  function automatic logic [REG_W-1:0] valid_bits();
    logic [REG_W-1:0] m;
    m = '0;
    for (int f = F_RXG; f <= F_GST; f++) m[fidx(f)] = 1'b1;
    for (int f = F_TXE; f <= F_RXB; f++) m[fidx(f)] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] VALID_MASK = valid_bits();
endpackage

// File: rtl/evt_lvl_edge.sv
module evt_lvl_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] chg_o
);
  logic         primed_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= lvl_i[g];
    end
    // first sample after reset only primes the history
    assign chg_o[g] = primed_q & (lvl_i[g] ^ prev_q[g]);
  end

  assert_hist_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev_q == $past(lvl_i)));
endmodule

// File: rtl/evt_gstop.sv
module evt_gstop (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  input  logic frame_active_i,
  output logic done_o
);
  logic pend_q;
  logic want;

  assign want   = cmd_i | pend_q;
  assign done_o = want & ~frame_active_i;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= want & frame_active_i;
  end

  assert_gs_defer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && frame_active_i) |-> !done_o);
  assert_gs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && frame_active_i) |=> pend_q);
  assert_gs_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !pend_q);
endmodule

// File: rtl/evt_regbank.sv
module evt_regbank #(
  parameter int              W     = 16,
  parameter logic [W-1:0]    VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         wr_ev_i,
  input  logic         wr_mask_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ev_o,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] ev_q, mask_q, clr_v, set_v;

  assign clr_v = wr_ev_i ? wdata_i : '0;
  assign set_v = set_i & VALID;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q   <= '0;
      mask_q <= '0;
    end else begin
      ev_q <= ((ev_q & ~clr_v) | set_v) & VALID;
      if (wr_mask_i) mask_q <= wdata_i & VALID;
    end
  end

  assign ev_o   = ev_q;
  assign mask_o = mask_q;

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_q & ~VALID) == '0) && ((mask_q & ~VALID) == '0));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_q & $past(set_v)) == $past(set_v)));
  assert_zero_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_q & $past(ev_q & ~clr_v)) == $past(ev_q & ~clr_v)));
  assert_mask_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask_i |=> $stable(mask_q));
endmodule

// File: rtl/hdlc_evt_unit.sv
module hdlc_evt_unit
  import hdlc_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_flag,
  input  logic             lvl_idle,
  input  logic             lvl_carrier,
  input  logic             pls_rx_glitch,
  input  logic             pls_tx_glitch,
  input  logic             pls_tx_err,
  input  logic             pls_rx_frame,
  input  logic             pls_busy,
  input  logic             pls_tx_buf,
  input  logic             pls_rx_buf,
  input  logic             tx_frame_active,
  input  logic             gstop_cmd,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);
  logic [N_LVL-1:0] lvl_v, chg_v;
  logic             gs_done;
  logic [REG_W-1:0] set_v, ev_v, mask_v;

  assign lvl_v = {lvl_carrier, lvl_flag, lvl_idle};

  evt_lvl_edge #(.W(N_LVL)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (lvl_v),
    .chg_o (chg_v)
  );

  evt_gstop u_gstop (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_i          (gstop_cmd),
    .frame_active_i (tx_frame_active),
    .done_o         (gs_done)
  );

  always_comb begin
    set_v = '0;
    set_v[fidx(F_RXG)] = pls_rx_glitch;
    set_v[fidx(F_TXG)] = pls_tx_glitch;
    set_v[fidx(F_CAR)] = chg_v[2];
    set_v[fidx(F_FLG)] = chg_v[1];
    set_v[fidx(F_IDL)] = chg_v[0];
    set_v[fidx(F_GST)] = gs_done;
    set_v[fidx(F_TXE)] = pls_tx_err;
    set_v[fidx(F_RXF)] = pls_rx_frame;
    set_v[fidx(F_BSY)] = pls_busy;
    set_v[fidx(F_TXB)] = pls_tx_buf;
    set_v[fidx(F_RXB)] = pls_rx_buf;
  end

  evt_regbank #(.W(REG_W), .VALID(VALID_MASK)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_v),
    .wr_ev_i   (reg_wr & ~reg_sel),
    .wr_mask_i (reg_wr & reg_sel),
    .wdata_i   (reg_wdata),
    .ev_o      (ev_v),
    .mask_o    (mask_v)
  );

  assign reg_rdata = reg_sel ? mask_v : ev_v;
  assign irq       = |(ev_v & mask_v);

  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq);
  assert_rst_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (ev_v == '0 && mask_v == '0));
endmodule

// File: tb/hdlc_evt_unit_tb.sv
module hdlc_evt_unit_tb;
  typedef struct packed {
    logic [6:0]  pls;   // rxg txg txe rxf bsy txb rxb
    logic [2:0]  lvl;   // flag idle carrier
    logic        wr;
    logic        sel;
    logic [15:0] wd;
    logic [15:0] exp_ev;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{7'b1000000, 3'b000, 1'b0, 1'b0, 16'h0000, 16'h1000, 1'b0}, // R3 rxg
    '{7'b0100000, 3'b000, 1'b0, 1'b0, 16'h0000, 16'h1800, 1'b0}, // R3 txg
    '{7'b0000000, 3'b000, 1'b1, 1'b0, 16'h0800, 16'h1000, 1'b0}, // R7 clear
    '{7'b0000000, 3'b000, 1'b1, 1'b0, 16'h0000, 16'h1000, 1'b0}, // R7 zero
    '{7'b0000000, 3'b000, 1'b1, 1'b1, 16'hFFFF, 16'h1000, 1'b1}, // R9 mask
    '{7'b0000000, 3'b000, 1'b1, 1'b0, 16'h1000, 16'h0000, 1'b0}, // R10 drop
    '{7'b0000000, 3'b100, 1'b0, 1'b0, 16'h0000, 16'h0200, 1'b1}, // R4 flag rise
    '{7'b0000000, 3'b100, 1'b1, 1'b0, 16'h0200, 16'h0000, 1'b0}, // R4 hold
    '{7'b0000000, 3'b000, 1'b0, 1'b0, 16'h0000, 16'h0200, 1'b1}, // R4 flag fall
    '{7'b0000000, 3'b011, 1'b1, 1'b0, 16'h0200, 16'h0500, 1'b1}, // R4 idle+car
    '{7'b0011111, 3'b011, 1'b0, 1'b0, 16'h0000, 16'h051F, 1'b1}, // R3 rest
    '{7'b0000000, 3'b011, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 1'b0}, // R7 all
    '{7'b0000100, 3'b011, 1'b1, 1'b1, 16'h0008, 16'h0004, 1'b0}, // R10 masked
    '{7'b0001000, 3'b011, 1'b0, 1'b0, 16'h0000, 16'h000C, 1'b1}, // R9 rxf
    '{7'b0000000, 3'b011, 1'b1, 1'b0, 16'h0004, 16'h0008, 1'b1}, // R10 stays
    '{7'b0001000, 3'b011, 1'b1, 1'b0, 16'h0008, 16'h0008, 1'b1}, // R8 set wins
    '{7'b0000000, 3'b011, 1'b1, 1'b0, 16'h0008, 16'h0000, 1'b0}, // R10 clear
    '{7'b0000000, 3'b011, 1'b1, 1'b0, 16'hE060, 16'h0000, 1'b0}  // R2 rsvd
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic lvl_flag = 0, lvl_idle = 0, lvl_carrier = 0;
  logic pls_rx_glitch = 0, pls_tx_glitch = 0, pls_tx_err = 0, pls_rx_frame = 0;
  logic pls_busy = 0, pls_tx_buf = 0, pls_rx_buf = 0;
  logic tx_frame_active = 0, gstop_cmd = 0, reg_sel = 0, reg_wr = 0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hdlc_evt_unit u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    {pls_rx_glitch, pls_tx_glitch, pls_tx_err, pls_rx_frame, pls_busy, pls_tx_buf, pls_rx_buf} = '0;
    reg_wr = 0; reg_sel = 0; reg_wdata = '0; gstop_cmd = 0;
  endtask

  task automatic step();
    @(posedge clk); #1; idle_bus(); @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 event", reg_rdata, 16'h0000);
    reg_sel = 1; #1;
    chk("R1 mask", reg_rdata, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    reg_sel = 0;

    for (int i = 0; i < NV; i++) begin
      {pls_rx_glitch, pls_tx_glitch, pls_tx_err, pls_rx_frame, pls_busy, pls_tx_buf, pls_rx_buf} = VT[i].pls;
      {lvl_flag, lvl_idle, lvl_carrier} = VT[i].lvl;
      reg_wr = VT[i].wr; reg_sel = VT[i].sel; reg_wdata = VT[i].wd;
      @(posedge clk); #1; idle_bus(); #1;
      chk($sformatf("R3/R4/R7/R8/R9 vec%0d ev", i), reg_rdata, VT[i].exp_ev);
      chk($sformatf("R9/R10 vec%0d irq", i), {15'd0, irq}, {15'd0, VT[i].exp_irq});
      @(negedge clk);
    end

    // R2 mask readback of reserved bits
    reg_wr = 1; reg_sel = 1; reg_wdata = 16'hFFFF; step();
    reg_sel = 1; #1;
    chk("R2 mask rsvd", reg_rdata, 16'h1F9F);
    reg_sel = 0;

    // R6 deferred graceful stop
    tx_frame_active = 1; gstop_cmd = 1; step();
    chk("R6 not yet", reg_rdata & 16'h0080, 16'h0000);
    step(); step();
    chk("R6 still pending", reg_rdata & 16'h0080, 16'h0000);
    tx_frame_active = 0; step();
    chk("R6 after frame", reg_rdata & 16'h0080, 16'h0080);
    reg_wr = 1; reg_wdata = 16'h0080; step();
    chk("R7 gstop cleared", reg_rdata, 16'h0000);
    step();
    chk("R6 no repeat", reg_rdata, 16'h0000);

    // R5 immediate graceful stop
    gstop_cmd = 1; step();
    chk("R5 immediate", reg_rdata, 16'h0080);
    chk("R9 gstop irq", {15'd0, irq}, 16'd1);

    // R4 level high at reset release
    rst_n = 0; lvl_flag = 1; lvl_idle = 0; lvl_carrier = 1;
    step(); step();
    chk("R1 reset again", reg_rdata, 16'h0000);
    rst_n = 1; step(); step();
    chk("R4 no event at reset release", reg_rdata, 16'h0000);
    lvl_carrier = 0; step();
    chk("R4 carrier fall", reg_rdata, 16'h0400);

    finish_run();
  end
endmodule